// File: doc/BRIEF.md
# Watchdog Timer with Selectable Response

This block guards a processor against runaway code. A binary counter advances on each tick of a prescaled clock. Software picks one of four detection periods and must write a clear key to the command register again and again, each time before the period runs out. If it stops doing so, the counter overflows and the block raises a response. The response is either an active-low reset request, held for a fixed number of clock cycles, or a one-cycle non-maskable interrupt pulse.

The block is enabled from reset and starts in reset-response mode. The response choice can be made once after each reset; later attempts to change it are dropped. In interrupt mode the counter wraps and keeps running, so the block can also serve as a fixed-interval timer. While the chip sits in STOP or IDLE the count is frozen, and it carries on from the held value when the low-power mode ends.

A small state machine sequences the block. ST_COUNT is normal counting. The machine moves to ST_PAUSE when a low-power input is raised and back to ST_COUNT when both drop. From ST_COUNT or ST_PAUSE it moves to ST_BITE on an overflow in reset mode, and it returns from ST_BITE to ST_COUNT after the hold time.

Top module: `wdog_guard`

## Requirements
- R1: After `rst_n` the block counts with no software action, starting from zero. `rst_req_n` is high, `nmi_pulse` is low and the period select is 0.
- R2: Only clock cycles with `tick_in` high and both low-power inputs low advance the counter. With period select `s`, the timeout fires on tick number 2^(TAP_BASE+TAP_STEP*s) after the last clear. The select sits in control register (address 0) bits [1:0].
- R3: In reset mode a timeout drives `rst_req_n` low for exactly BITE_LEN clock cycles, starting in the cycle after the overflowing tick. Ticks during that window are ignored, and counting afterwards restarts from zero.
- R4: In interrupt mode a timeout drives `nmi_pulse` high for exactly one cycle, in the cycle after the overflowing tick. The counter wraps to zero and keeps counting, so the pulses repeat every period.
- R5: Control bit 7 chooses the response: 1 selects reset and 0 selects interrupt. The reset value is 1.
- R6: Only the first write to address 0 after reset sets bit 7. Its bit 7 in later writes is ignored until the next reset, but bits [1:0] stay writable.
- R7: A write of the key 0x4E to address 1 zeroes the counter. Any other value written there leaves the count unchanged.
- R8: A key write in the same cycle as an overflowing tick wins: no timeout fires and the counter becomes zero.
- R9: While `stop_mode` or `idle_mode` is high the count holds and ticks are lost. Counting resumes from the held value when both are low.
- R10: `rst_req_n` low and `nmi_pulse` high never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = command register |
| wr_data | input | 8 | Write data |
| tick_in | input | 1 | Prescaled counting tick, one clock wide |
| stop_mode | input | 1 | Chip is in STOP or its warm-up |
| idle_mode | input | 1 | Chip is in IDLE |
| rst_req_n | output | 1 | Active-low reset request |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The hardest case to reach is the write-once latch meeting the rest of the register: a later control write must change the period but not the response. The only way to see this from the ports is to let a full timeout happen and watch which output moves. The bench therefore sweeps every period in both modes. Each sweep step writes the control register with the opposite response bit, and the measured timeouts show which bit held. A tiny tap configuration keeps those timeouts short. The exact coincidence of a key write with the overflowing tick is reached by counting ticks up to one short of the period and then driving both on the same clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_PAUSE = 2'd1,
        ST_BITE  = 2'd2
    } wdog_state_e;

    localparam int RESP_BIT = 7;     // control bit choosing the response
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_CMD  = 1'b1;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          SEL_W   = 2,
    parameter logic [7:0]  CLR_KEY = 8'h4E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [7:0]       wr_data,
    output logic [SEL_W-1:0] tap_sel,
    output logic             mode_rst,
    output logic             mode_lock,
    output logic             key_hit
);

    logic ctrl_wr;

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
        key_hit = wr_en && (wr_addr == ADDR_CMD) && (wr_data == CLR_KEY);
    end

    // Period select: writable at any time.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_sel <= '0;
        end else if (ctrl_wr) begin
            tap_sel <= wr_data[SEL_W-1:0];
        end
    end

    // Response choice: the first control write after reset fixes it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_rst  <= 1'b1;
            mode_lock <= 1'b0;
        end else if (ctrl_wr && !mode_lock) begin
            mode_rst  <= wr_data[RESP_BIT];
            mode_lock <= 1'b1;
        end
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int TAP_BASE = 15,
    parameter int TAP_STEP = 2,
    parameter int NUM_TAPS = 4,
    parameter int SEL_W    = 2,
    parameter int CNT_W    = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             zero,
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] count,
    output logic             at_top
);

    logic [CNT_W-1:0] tap_mask [NUM_TAPS];
    logic [CNT_W-1:0] cur_mask;

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int TW = TAP_BASE + TAP_STEP * g;
        assign tap_mask[g] = {CNT_W{1'b1}} >> (CNT_W - TW);
    end

    always_comb begin
        cur_mask = tap_mask[sel];
        at_top   = ((count & cur_mask) == cur_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (zero) begin
            count <= '0;
        end else if (adv) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int BITE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic low_pwr,
    input  logic key_hit,
    input  logic at_top,
    input  logic mode_rst,
    output logic cnt_adv,
    output logic cnt_zero,
    output logic rst_req_n,
    output logic nmi_pulse
);

    localparam int BW = $clog2(BITE_LEN + 1);

    wdog_state_e   state_q, state_d;
    logic [BW-1:0] bite_q;
    logic          ovf;

    always_comb begin
        cnt_adv  = (state_q != ST_BITE) && !low_pwr && tick && !key_hit;
        ovf      = cnt_adv && at_top;
        cnt_zero = key_hit || ovf || (state_q == ST_BITE);
        state_d  = state_q;
        unique case (state_q)
            ST_COUNT: begin
                if (ovf && mode_rst)  state_d = ST_BITE;
                else if (low_pwr)     state_d = ST_PAUSE;
            end
            ST_PAUSE: begin
                if (ovf && mode_rst)  state_d = ST_BITE;
                else if (!low_pwr)    state_d = ST_COUNT;
            end
            ST_BITE: begin
                if (bite_q == BW'(BITE_LEN - 1)) state_d = ST_COUNT;
            end
            default: state_d = ST_COUNT;
        endcase
    end

    // State register and hold-time counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
            bite_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_BITE) bite_q <= bite_q + BW'(1);
            else                    bite_q <= '0;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req_n <= 1'b1;
            nmi_pulse <= 1'b0;
        end else begin
            rst_req_n <= (state_d != ST_BITE);
            nmi_pulse <= ovf && !mode_rst;
        end
    end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
    parameter int         TAP_BASE = 15,
    parameter int         TAP_STEP = 2,
    parameter int         NUM_TAPS = 4,
    parameter int         BITE_LEN = 16,
    parameter logic [7:0] CLR_KEY  = 8'h4E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       tick_in,
    input  logic       stop_mode,
    input  logic       idle_mode,
    output logic       rst_req_n,
    output logic       nmi_pulse
);

    localparam int SEL_W = $clog2(NUM_TAPS);
    localparam int CNT_W = TAP_BASE + TAP_STEP * (NUM_TAPS - 1);

    logic [SEL_W-1:0] tap_sel;
    logic             mode_rst;
    logic             mode_lock;
    logic             key_hit;
    logic             cnt_adv;
    logic             cnt_zero;
    logic             at_top;
    logic [CNT_W-1:0] cnt_q;
    logic             low_pwr;

    assign low_pwr = stop_mode || idle_mode;

    wdog_regs #(
        .SEL_W   (SEL_W),
        .CLR_KEY (CLR_KEY)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .tap_sel   (tap_sel),
        .mode_rst  (mode_rst),
        .mode_lock (mode_lock),
        .key_hit   (key_hit)
    );

    wdog_counter #(
        .TAP_BASE (TAP_BASE),
        .TAP_STEP (TAP_STEP),
        .NUM_TAPS (NUM_TAPS),
        .SEL_W    (SEL_W),
        .CNT_W    (CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (cnt_adv),
        .zero   (cnt_zero),
        .sel    (tap_sel),
        .count  (cnt_q),
        .at_top (at_top)
    );

    wdog_fsm #(
        .BITE_LEN (BITE_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_in),
        .low_pwr   (low_pwr),
        .key_hit   (key_hit),
        .at_top    (at_top),
        .mode_rst  (mode_rst),
        .cnt_adv   (cnt_adv),
        .cnt_zero  (cnt_zero),
        .rst_req_n (rst_req_n),
        .nmi_pulse (nmi_pulse)
    );

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
    parameter int         BITE_LEN = 16,
    parameter int         CNT_W    = 21,
    parameter logic [7:0] CLR_KEY  = 8'h4E
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_addr,
    input logic [7:0]       wr_data,
    input logic             tick_in,
    input logic             stop_mode,
    input logic             idle_mode,
    input logic             rst_req_n,
    input logic             nmi_pulse,
    input logic [CNT_W-1:0] count,
    input logic             mode_rst,
    input logic             mode_lock
);

    localparam int LW = $clog2(BITE_LEN + 2);

    logic [LW-1:0] low_run;
    logic          key_wr;

    assign key_wr = wr_en && wr_addr && (wr_data == CLR_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          low_run <= '0;
        else if (!rst_req_n) low_run <= low_run + LW'(1);
        else                 low_run <= '0;
    end

    // R3: the reset request never outlasts its hold time
    a_r3_bite_cap: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req_n |-> (low_run < LW'(BITE_LEN)));

    // R3: the reset request lasts the whole hold time
    a_r3_bite_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_n) |-> (low_run == LW'(BITE_LEN)));

    // R2: a reset request only starts after a counted tick
    a_r2_fell_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_n) |-> $past(tick_in && !stop_mode && !idle_mode));

    // R4: the interrupt request is a single-cycle pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |=> !nmi_pulse);

    // R5: the reset response is in force until the first control write
    a_r5_default_rst: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_lock |-> mode_rst);

    // R6: the response choice does not change once locked
    a_r6_locked: assert property (@(posedge clk) disable iff (!rst_n)
        mode_lock |=> $stable(mode_rst));

    // R7: the key write zeroes the count
    a_r7_key_clears: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> (count == '0));

    // R9: the count holds while a low-power mode is active
    a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        ((stop_mode || idle_mode) && !key_wr) |=> $stable(count));

    // R10: reset and interrupt requests are never active together
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_pulse && !rst_req_n));

endmodule

bind wdog_guard wdog_guard_chk #(
    .BITE_LEN (BITE_LEN),
    .CNT_W    (CNT_W),
    .CLR_KEY  (CLR_KEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tick_in   (tick_in),
    .stop_mode (stop_mode),
    .idle_mode (idle_mode),
    .rst_req_n (rst_req_n),
    .nmi_pulse (nmi_pulse),
    .count     (cnt_q),
    .mode_rst  (mode_rst),
    .mode_lock (mode_lock)
);

// File: tb/test_wdog_guard.sv
module test_wdog_guard;

    localparam int         TB  = 2;
    localparam int         TS  = 1;
    localparam int         NT  = 4;
    localparam int         BL  = 16;
    localparam logic [7:0] KEY = 8'h4E;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic       wr_addr;
    logic [7:0] wr_data;
    logic       tick_in;
    logic       stop_mode;
    logic       idle_mode;
    logic       rst_req_n;
    logic       nmi_pulse;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    wdog_guard #(
        .TAP_BASE (TB),
        .TAP_STEP (TS),
        .NUM_TAPS (NT),
        .BITE_LEN (BL),
        .CLR_KEY  (KEY)
    ) i_wdog_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .tick_in   (tick_in),
        .stop_mode (stop_mode),
        .idle_mode (idle_mode),
        .rst_req_n (rst_req_n),
        .nmi_pulse (nmi_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Inputs are set after a falling edge; outputs are read at the next one.
    task automatic cyc(input bit t, input bit st, input bit id);
        tick_in   = t;
        stop_mode = st;
        idle_mode = id;
        @(negedge clk);
    endtask

    task automatic wr(input bit a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        cyc(1'b0, 1'b0, 1'b0);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
        repeat (3) cyc(1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    // Deliver n counted ticks; return how many samples showed any response.
    task automatic ticks(input int n, output int ev);
        ev = 0;
        for (int k = 0; k < n; k++) begin
            cyc(1'b1, 1'b0, 1'b0);
            if (!rst_req_n || nmi_pulse) ev++;
        end
    endtask

    // Count consecutive low samples of the reset request, ticking throughout.
    task automatic bite_len(output int n);
        n = 0;
        while (!rst_req_n && n < 100) begin
            n++;
            cyc(1'b1, 1'b0, 1'b0);
        end
    endtask

    function automatic int period(input int sel);
        return 1 << (TB + TS * sel);
    endfunction

    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ev;
        int n;
        tick_in = 1'b0; stop_mode = 1'b0; idle_mode = 1'b0;
        do_reset();

        // R1: quiet outputs after reset
        check("R1 rst_req_n after reset", int'(rst_req_n), 1);
        check("R1 nmi_pulse after reset", int'(nmi_pulse), 0);

        // R1 R5: enabled without writes, reset response, shortest period
        ticks(period(0) - 1, ev);
        check("R1 no early timeout", ev, 0);
        ticks(1, ev);
        check("R5 default reset response", int'(rst_req_n), 0);
        check("R10 no interrupt with reset", int'(nmi_pulse), 0);

        // R3: hold length with ticks ignored, then restart from zero
        bite_len(n);
        check("R3 hold length", n, BL);
        ticks(period(0) - 1, ev);
        check("R3 restart from zero, no early timeout", ev, 0);
        ticks(1, ev);
        check("R3 restart timeout", int'(rst_req_n), 0);
        bite_len(n);

        // R2 R6: sweep periods in reset mode; later writes try interrupt mode
        wr(1'b0, 8'h80);
        for (int s = 0; s < NT; s++) begin
            wr(1'b0, 8'(s));
            wr(1'b1, KEY);
            ticks(period(s) - 1, ev);
            check($sformatf("R2 sel=%0d no early timeout", s), ev, 0);
            ticks(1, ev);
            check($sformatf("R6 sel=%0d reset kept", s), int'(rst_req_n), 0);
            check($sformatf("R6 sel=%0d no interrupt", s), int'(nmi_pulse), 0);
            bite_len(n);
            check($sformatf("R3 sel=%0d hold length", s), n, BL);
        end

        // R4 R5 R6: interrupt mode chosen once, later reset writes ignored
        do_reset();
        wr(1'b0, 8'h00);
        for (int s = 0; s < NT; s++) begin
            wr(1'b0, 8'h80 | 8'(s));
            wr(1'b1, KEY);
            ticks(period(s) - 1, ev);
            check($sformatf("R2 nmi sel=%0d no early event", s), ev, 0);
            ticks(1, ev);
            check($sformatf("R4 sel=%0d pulse", s), int'(nmi_pulse), 1);
            check($sformatf("R10 sel=%0d reset quiet", s), int'(rst_req_n), 1);
            ticks(period(s) - 1, ev);
            check($sformatf("R4 sel=%0d single pulse, no early event", s), ev, 0);
            ticks(1, ev);
            check($sformatf("R4 sel=%0d periodic pulse", s), int'(nmi_pulse), 1);
        end

        // R7: key clears, wrong values do not
        wr(1'b0, 8'h00);
        wr(1'b1, KEY);
        ticks(period(0) - 1, ev);
        wr(1'b1, KEY);
        ticks(period(0) - 1, ev);
        check("R7 key restarts period", ev, 0);
        ticks(1, ev);
        check("R7 timeout after key", int'(nmi_pulse), 1);
        wr(1'b1, KEY);
        ticks(period(0) - 1, ev);
        wr(1'b1, 8'h4F);
        wr(1'b1, 8'h00);
        ticks(1, ev);
        check("R7 wrong value does not clear", int'(nmi_pulse), 1);

        // R8: key and overflowing tick together
        wr(1'b1, KEY);
        ticks(period(0) - 1, ev);
        wr_en = 1'b1; wr_addr = 1'b1; wr_data = KEY;
        cyc(1'b1, 1'b0, 1'b0);
        wr_en = 1'b0;
        check("R8 no pulse on colliding key", int'(nmi_pulse), 0);
        ticks(period(0) - 1, ev);
        check("R8 counter zeroed", ev, 0);
        ticks(1, ev);
        check("R8 timeout after collision", int'(nmi_pulse), 1);

        // R9: freeze in STOP and IDLE, resume from held count
        wr(1'b1, KEY);
        ticks(period(0) - 2, ev);
        ev = 0;
        for (int k = 0; k < 40; k++) begin
            cyc(1'b1, 1'b1, 1'b0);
            if (nmi_pulse) ev++;
        end
        for (int k = 0; k < 40; k++) begin
            cyc(1'b1, 1'b0, 1'b1);
            if (nmi_pulse) ev++;
        end
        check("R9 no timeout while frozen", ev, 0);
        ticks(1, ev);
        check("R9 held count, no early timeout", ev, 0);
        ticks(1, ev);
        check("R9 resumed timeout", int'(nmi_pulse), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule